// File: doc/BRIEF.md
# Reset Supervisor with Shared Pushbutton Pin

This block supervises a system reset line and produces an access-inhibit signal for the logic it guards. A single open-drain pin carries the reset. The block pulls it low during power failure, during the hold that follows power-up and after a watchdog request. An external pushbutton can also pull the same pin low. The pin is modelled as a pull-low enable (`pin_pull_o`) plus the sampled pad level (`pin_in_i`). The pad level is low whenever the block or the button pulls it.

When a button press is seen, the block pulls the pin low for a debounce interval. It then releases the pin and waits for the pad to go high again. After that it issues a full reset pulse. The power-up hold is lengthened by an oscillator start-up allowance when the oscillator was switched off during backup. All intervals are counted in clock cycles and set by parameters.

All pins are plain level signals. There is no streaming data path, so no valid/ready handshake and no back-pressure apply.

Top module: `reset_supervisor`

## Requirements
- R1: While `pwr_fail_i` is 1, `pin_pull_o` and `access_block_o` are 1 from the next clock. Both are 1 throughout the `rst_n` reset.
- R2: After `pwr_fail_i` falls with `osc_off_i` at 0, `pin_pull_o` stays 1 for exactly HOLD_CYC cycles and then drops to 0.
- R3: If `osc_off_i` is 1 in the cycle where `pwr_fail_i` falls, the hold lasts HOLD_CYC + OSC_START_CYC cycles.
- R4: `pin_in_i` passes through a two-flop synchronizer. In the idle state, a synchronized high-to-low change of the pad level counts as a button press.
- R5: A button press makes `pin_pull_o` 1 for exactly DEBOUNCE_CYC cycles.
- R6: After the debounce interval the pin is released. While the synchronized pad stays low, the block keeps `pin_pull_o` at 0 and `access_block_o` at 1.
- R7: When the synchronized pad reads high after debounce, `pin_pull_o` is 1 for exactly HOLD_CYC cycles. The block then returns to idle.
- R8: A `wdog_req_i` of 1 in the idle state gives a `pin_pull_o` pulse of exactly HOLD_CYC cycles. A request in any other state has no effect.
- R9: `access_block_o` is 1 whenever the block is not idle or the synchronized pad level is low. It is 0 otherwise.
- R10: `pwr_fail_i` overrides every state. The sequence then restarts from the power-fail state.
- R11: The block's own pulls never count as a button press. A press is recognized only after the pad has been seen high while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous block reset |
| pwr_fail_i | input | 1 | Digital supply-out-of-tolerance indication |
| wdog_req_i | input | 1 | Watchdog reset request |
| osc_off_i | input | 1 | Oscillator was disabled in backup; lengthens the power-up hold |
| pin_in_i | input | 1 | Sampled level of the shared reset pad |
| pin_pull_o | output | 1 | 1 = pull the reset pad low; 0 = high impedance |
| access_block_o | output | 1 | 1 = access to the guarded logic is inhibited |

## Verification
The assertions take two things for granted. First, the control inputs are synchronous to `clk`. Second, `pin_in_i` really is the wired level of the pad, so it reads low whenever `pin_pull_o` is 1. The bench builds the pad as the wired-AND of the block's pull and a modelled button, changes every input on the falling clock edge, and holds each button press or release for whole cycles. A behavioural model runs alongside the block and is compared with it on every cycle. Directed runs measure every pulse length: presses shorter and longer than the debounce interval, watchdog requests inside and outside idle, and power failure arriving mid-sequence.

// File: rtl/rsup_pkg.sv
package rsup_pkg;
  typedef enum logic [2:0] {
    ST_PFAIL    = 3'd0,
    ST_HOLD     = 3'd1,
    ST_IDLE     = 3'd2,
    ST_DEBOUNCE = 3'd3,
    ST_WAIT_REL = 3'd4,
    ST_PULSE    = 3'd5
  } rsup_state_e;
endpackage

// File: rtl/rsup_sync2.sv
module rsup_sync2 #(
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic s1, s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= RESET_VAL;
      s2 <= RESET_VAL;
    end else begin
      s1 <= d_i;
      s2 <= s1;
    end
  end
  assign q_o = s2;
endmodule

// File: rtl/rsup_timer.sv
module rsup_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] value_i,
  output logic         zero_o
);
  logic [W-1:0] cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load_i)       cnt <= value_i;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end
  assign zero_o = (cnt == '0);
endmodule

// File: rtl/rsup_press_detect.sv
module rsup_press_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic idle_i,
  input  logic pin_s_i,
  output logic press_o
);
  // Arms only once the pad is seen high while idle, so self-driven lows are masked.
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= idle_i & pin_s_i;
  end
  assign press_o = armed & idle_i & ~pin_s_i;
endmodule

// File: rtl/reset_supervisor.sv
module reset_supervisor #(
  parameter int HOLD_CYC      = 24,
  parameter int DEBOUNCE_CYC  = 10,
  parameter int OSC_START_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_fail_i,
  input  logic wdog_req_i,
  input  logic osc_off_i,
  input  logic pin_in_i,
  output logic pin_pull_o,
  output logic access_block_o
);
  import rsup_pkg::*;

  localparam int LONGEST = HOLD_CYC + OSC_START_CYC + DEBOUNCE_CYC;
  localparam int CW      = $clog2(LONGEST + 1);
  localparam logic [CW-1:0] LD_HOLD = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] LD_SLOW = CW'(HOLD_CYC + OSC_START_CYC - 1);
  localparam logic [CW-1:0] LD_DEB  = CW'(DEBOUNCE_CYC - 1);

  rsup_state_e state, nxt;
  logic          pin_s, press, tmr_zero, tmr_load;
  logic [CW-1:0] tmr_val;

  rsup_sync2 #(.RESET_VAL(1'b0)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_in_i), .q_o(pin_s)
  );

  rsup_press_detect u_press (
    .clk(clk), .rst_n(rst_n), .idle_i(state == ST_IDLE),
    .pin_s_i(pin_s), .press_o(press)
  );

  rsup_timer #(.W(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load),
    .value_i(tmr_val), .zero_o(tmr_zero)
  );

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_PFAIL: if (!pwr_fail_i) begin
        nxt      = ST_HOLD;
        tmr_load = 1'b1;
        tmr_val  = osc_off_i ? LD_SLOW : LD_HOLD;
      end
      ST_HOLD:     if (tmr_zero) nxt = ST_IDLE;
      ST_IDLE: begin
        if (wdog_req_i) begin
          nxt      = ST_PULSE;
          tmr_load = 1'b1;
          tmr_val  = LD_HOLD;
        end else if (press) begin
          nxt      = ST_DEBOUNCE;
          tmr_load = 1'b1;
          tmr_val  = LD_DEB;
        end
      end
      ST_DEBOUNCE: if (tmr_zero) nxt = ST_WAIT_REL;
      ST_WAIT_REL: if (pin_s) begin
        nxt      = ST_PULSE;
        tmr_load = 1'b1;
        tmr_val  = LD_HOLD;
      end
      ST_PULSE:    if (tmr_zero) nxt = ST_IDLE;
      default:     nxt = ST_PFAIL;
    endcase
    if (pwr_fail_i) nxt = ST_PFAIL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_PFAIL;
    else        state <= nxt;
  end

  assign pin_pull_o = (state == ST_PFAIL) || (state == ST_HOLD) ||
                      (state == ST_DEBOUNCE) || (state == ST_PULSE);
  assign access_block_o = (state != ST_IDLE) || !pin_s;

  AST_PFAIL_PULLS: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail_i |=> (pin_pull_o && access_block_o)); // R1
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && !tmr_zero && !pwr_fail_i) |=> (state == ST_HOLD && pin_pull_o)); // R2
  AST_SLOW_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PFAIL && !pwr_fail_i && osc_off_i) |=> (state == ST_HOLD && !tmr_zero)); // R3
  AST_DEB_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEBOUNCE && tmr_zero && !pwr_fail_i) |=> !pin_pull_o); // R6
  AST_RELEASE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_REL && pin_s && !pwr_fail_i) |=> pin_pull_o); // R7
  AST_WDOG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && wdog_req_i && !pwr_fail_i) |=> (state == ST_PULSE)); // R8
  AST_PULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    pin_pull_o |-> access_block_o); // R9
endmodule

// File: tb/tb_reset_supervisor.sv
module tb_reset_supervisor;
  localparam int HOLD = 24;
  localparam int DEB  = 10;
  localparam int OSC  = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pf = 1'b1, wd = 1'b0, osc = 1'b0, btn = 1'b0;
  logic pull, blk;
  wire  pin = !(pull || btn);

  reset_supervisor #(.HOLD_CYC(HOLD), .DEBOUNCE_CYC(DEB), .OSC_START_CYC(OSC)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_fail_i(pf), .wdog_req_i(wd), .osc_off_i(osc),
    .pin_in_i(pin), .pin_pull_o(pull), .access_block_o(blk)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Behavioural reference: phases 0 pfail,1 hold,2 idle,3 debounce,4 wait,5 pulse
  int  ms = 0, mleft = 0;
  bit  seen_high = 0;
  bit  sq[$] = '{1'b0, 1'b0};
  string tag_of[6] = '{"R1", "R2", "R9", "R5", "R6", "R7"};

  function automatic bit m_pull(int s);
    return (s == 0) || (s == 1) || (s == 3) || (s == 5);
  endfunction

  always @(posedge clk) begin
    bit ps, mp_old, fell;
    int nx, nl;
    if (!rst_n) begin
      ms = 0; mleft = 0; seen_high = 0; sq = '{1'b0, 1'b0};
    end else begin
      ps = sq[0];
      mp_old = m_pull(ms);
      fell = seen_high && !ps && (ms == 2);
      nx = ms; nl = mleft;
      case (ms)
        0: if (!pf) begin nx = 1; nl = osc ? HOLD + OSC : HOLD; end
        1, 3, 5: if (mleft <= 1) nx = (ms == 3) ? 4 : 2; else nl = mleft - 1;
        2: if (wd) begin nx = 5; nl = HOLD; end
           else if (fell) begin nx = 3; nl = DEB; end
        4: if (ps) begin nx = 5; nl = HOLD; end
        default: nx = 0;
      endcase
      if (pf) nx = 0;
      seen_high = (ms == 2) && ps;
      ms = nx; mleft = nl;
      sq.push_back(!(mp_old || btn));
      void'(sq.pop_front());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(tag_of[ms], pull, m_pull(ms), "pin_pull_o vs model");
      chk("R9", blk, (ms != 2) || !sq[0], "access_block_o vs model");
    end
  end

  task automatic run_len(output int n);
    int g = 0;
    n = 0;
    while (!pull && g < 1000) begin @(negedge clk); g++; end
    while (pull && n < 10000) begin n++; @(negedge clk); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog run did not complete");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1", pull, 1, "pull during reset");
    chk("R1", blk, 1, "block during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", pull, 1, "pull while power fail");
    // R2 plain power-up hold
    pf = 1'b0; @(negedge clk);
    run_len(n); chk("R2", n, HOLD, "power-up hold length");
    // R3 stretched hold
    pf = 1'b1; repeat (5) @(negedge clk);
    osc = 1'b1; pf = 1'b0; @(negedge clk); osc = 1'b0;
    run_len(n); chk("R3", n, HOLD + OSC, "stretched hold length");
    repeat (6) @(negedge clk);
    chk("R9", blk, 0, "access open in idle");
    // R8 watchdog pulse, R11 no self-trigger afterwards
    wd = 1'b1; @(negedge clk); wd = 1'b0;
    run_len(n); chk("R8", n, HOLD, "watchdog pulse length");
    for (int i = 0; i < 30; i++) begin
      chk("R11", pull, 0, "no self-trigger after own pulse");
      @(negedge clk);
    end
    chk("R9", blk, 0, "access re-enabled after pulse");
    // R4/R5 long press
    btn = 1'b1;
    run_len(n); chk("R5", n, DEB, "debounce length on long press (R4 press seen)");
    chk("R6", pull, 0, "released after debounce");
    chk("R6", blk, 1, "blocked while button held");
    wd = 1'b1; @(negedge clk); wd = 1'b0;
    chk("R8", pull, 0, "watchdog ignored outside idle");
    repeat (10) @(negedge clk);
    chk("R6", pull, 0, "still waiting for release");
    chk("R9", blk, 1, "blocked while pad low");
    btn = 1'b0;
    run_len(n); chk("R7", n, HOLD, "pulse after release");
    repeat (8) @(negedge clk);
    chk("R9", blk, 0, "access open after press sequence");
    // short press released during debounce
    btn = 1'b1; repeat (3) @(negedge clk); btn = 1'b0;
    run_len(n); chk("R5", n, DEB, "debounce length on short press");
    run_len(n); chk("R7", n, HOLD, "pulse after short press");
    repeat (8) @(negedge clk);
    // R10 power fail while waiting for release
    btn = 1'b1;
    run_len(n); chk("R4", n, DEB, "press recognised");
    pf = 1'b1; @(negedge clk);
    chk("R10", pull, 1, "power fail overrides wait");
    chk("R10", blk, 1, "power fail blocks access");
    btn = 1'b0; repeat (5) @(negedge clk);
    pf = 1'b0; @(negedge clk);
    run_len(n); chk("R10", n, HOLD, "restart from power-fail hold");
    repeat (8) @(negedge clk);
    // R10 power fail during watchdog pulse
    wd = 1'b1; @(negedge clk); wd = 1'b0;
    repeat (3) @(negedge clk);
    pf = 1'b1; @(negedge clk);
    chk("R10", pull, 1, "power fail during pulse");
    pf = 1'b0; @(negedge clk);
    run_len(n); chk("R10", n, HOLD, "hold after fail in pulse");
    repeat (8) @(negedge clk);
    chk("R11", pull, 0, "idle at end");
    finish_run();
  end
endmodule